// File: doc/BRIEF.md
# Guarded Clock-Control Register Bank

This block holds the software-visible control registers of a microcontroller clock system. It sits on a simple synchronous register bus: address, write data and a write strobe in, registered read data out. It also watches a PLL-enable input. Software must first open a protect key before a register accepts a write. Some mode bits are one-way locks: once software sets them, they stay set until reset, and they freeze other clock settings.

The block does not build clocks itself. It drives the clock-select levels, the wait-count select for special-function-register accesses, the watchdog source select and the NMI pin mode. For each external clock-control field it also gives a one-cycle write-gate pulse. An outside clock controller lets a write to that field take effect only when its gate pulses.

Top module: `clkctl_guard_bank`

## Requirements
- R1: After synchronous reset the peripheral-select register reads 0x03, the mode register reads 0x00, the key register reads 0x00 and every write-gate is 0.
- R2: A write to the peripheral-select register (address 1) is applied only while key bit 0 is 1. Data bit 0 sets the timer clock select (1 = undivided clock) and data bit 1 sets the serial clock select. Read bits 7..2 are 0.
- R3: A write to the mode register (address 2) is applied only while key bit 1 is 1. The key register (address 0, bits 1..0) is always writable and reads back its value.
- R4: Mode bit 0 (1 = one wait, 0 = two waits) drives `sfr_one_wait_o`. A mode-register write that would change bit 0 while `pll_en_i` is 1 is dropped as a whole: no bit of the register changes.
- R5: Mode bit 1 is the clock lock. It is set by writing 1 and stays 1 until reset. While it is 1, all five field gates stay 0, and `bclk_keep_o` is 1.
- R6: Mode bit 2 is the watchdog lock and is sticky in the same way. While it is 1, `wdt_ring_src_o` is 1 and the stop-entry field gate (field 2) stays 0.
- R7: Mode bit 4 selects NMI mode (`nmi_mode_o`, 1 = NMI). It is sticky once set.
- R8: Mode-register read bits 3 and 7..5 always read 0, whatever was written.
- R9: A write to address 8+f pulses `field_gate_o[f]` for one cycle, starting the cycle after the write, when key bit 0 is 1 and no lock blocks that field. The fields are: 0 main-clock stop, 1 CPU source, 2 stop entry, 3 oscillation detect, 4 PLL control.
- R10: `rd_data_o` shows, one cycle after an address is presented, the register contents held before that edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| pll_en_i | input | 1 | PLL running |
| rd_data_o | output | 8 | Registered read data |
| tmr_clk_full_o | output | 1 | Timer clock undivided |
| sio_clk_full_o | output | 1 | Serial clock undivided |
| sfr_one_wait_o | output | 1 | One-wait SFR access |
| bclk_keep_o | output | 1 | Clock lock: bus clock not halted in wait |
| wdt_ring_src_o | output | 1 | Watchdog counts ring-oscillator clock |
| nmi_mode_o | output | 1 | Pin in NMI mode |
| field_gate_o | output | 5 | Per-field write-gate pulses |

## Verification
Several rules are checked by assertions on every cycle. A closed key leaves its register stable. A running PLL freezes the wait select. The three lock bits never fall. Active locks, or a closed key, force the affected gates low. Other behaviour only shows in the bench scenarios: a blocked write drops the whole word, a write that keeps the wait bit can still set a lock while the PLL runs, gates land on the correct field, and reads return the state held before the edge.

// File: rtl/ckb_pkg.sv
package ckb_pkg;
  localparam int NUM_FIELDS = 5;
  localparam int F_MSTOP  = 0;
  localparam int F_CPUSRC = 1;
  localparam int F_STOP   = 2;
  localparam int F_OSCDET = 3;
  localparam int F_PLL    = 4;

  typedef struct packed {
    logic nmi;
    logic wdt_lock;
    logic clk_lock;
    logic one_wait;
  } mode_t;
endpackage

// File: rtl/ckb_key_reg.sv
module ckb_key_reg #(
  parameter int KEY_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] wdata_i,
  output logic [KEY_W-1:0] key_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)     key_o <= '0;
    else if (wr_i) key_o <= wdata_i;
  end
endmodule

// File: rtl/ckb_mode_reg.sv
module ckb_mode_reg
  import ckb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_psel_i,
  input  logic              wr_mode_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        key_i,
  input  logic              pll_en_i,
  output logic [1:0]        psel_o,
  output mode_t             mode_o
);
  logic psel_ok, mode_hit, wait_change, mode_ok;

  assign psel_ok     = wr_psel_i && key_i[0];
  assign mode_hit    = wr_mode_i && key_i[1];
  assign wait_change = wdata_i[0] != mode_o.one_wait;
  assign mode_ok     = mode_hit && !(pll_en_i && wait_change);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      psel_o <= 2'b11;
      mode_o <= '0;
    end else begin
      if (psel_ok) psel_o <= wdata_i[1:0];
      if (mode_ok) begin
        mode_o.one_wait <= wdata_i[0];
        mode_o.clk_lock <= mode_o.clk_lock | wdata_i[1];
        mode_o.wdt_lock <= mode_o.wdt_lock | wdata_i[2];
        mode_o.nmi      <= mode_o.nmi      | wdata_i[4];
      end
    end
  end

  p_psel_key_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !key_i[0] |=> $stable(psel_o));
  p_mode_key_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    !key_i[1] |=> $stable(mode_o));
  p_wait_pll_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    pll_en_i |=> $stable(mode_o.one_wait));
  p_clk_sticky_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    mode_o.clk_lock |=> mode_o.clk_lock);
  p_wdt_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    mode_o.wdt_lock |=> mode_o.wdt_lock);
  p_nmi_sticky_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    mode_o.nmi |=> mode_o.nmi);
endmodule

// File: rtl/ckb_field_gate.sv
module ckb_field_gate
  import ckb_pkg::*;
#(
  parameter int NF = NUM_FIELDS
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [NF-1:0] hit_i,
  input  logic          key0_i,
  input  logic          clk_lock_i,
  input  logic          wdt_lock_i,
  output logic [NF-1:0] gate_o
);
  for (genvar f = 0; f < NF; f++) begin : g_field
    logic blocked;
    if (f == F_STOP) begin : g_stop
      assign blocked = clk_lock_i || wdt_lock_i;
    end else begin : g_plain
      assign blocked = clk_lock_i;
    end
    always_ff @(posedge clk_i) begin
      if (rst_i) gate_o[f] <= 1'b0;
      else       gate_o[f] <= hit_i[f] && key0_i && !blocked;
    end
  end

  p_gate_lock_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    clk_lock_i |=> gate_o == '0);
  p_stop_wdt_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    wdt_lock_i |=> !gate_o[F_STOP]);
  p_gate_key_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !key0_i |=> gate_o == '0);
  p_gate_single_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(gate_o));
endmodule

// File: rtl/clkctl_guard_bank.sv
module clkctl_guard_bank
  import ckb_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int A_KEY      = 0,
  parameter int A_PSEL     = 1,
  parameter int A_MODE     = 2,
  parameter int FIELD_BASE = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  wr_i,
  input  logic                  pll_en_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic                  tmr_clk_full_o,
  output logic                  sio_clk_full_o,
  output logic                  sfr_one_wait_o,
  output logic                  bclk_keep_o,
  output logic                  wdt_ring_src_o,
  output logic                  nmi_mode_o,
  output logic [NUM_FIELDS-1:0] field_gate_o
);
  localparam int KEY_W = 2;

  logic [KEY_W-1:0]      key_q;
  logic [1:0]            psel_q;
  mode_t                 mode_q;
  logic [NUM_FIELDS-1:0] field_hit;
  logic [DATA_W-1:0]     rd_next;

  ckb_key_reg #(.KEY_W(KEY_W)) u_key (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .wr_i    (wr_i && addr_i == ADDR_W'(A_KEY)),
    .wdata_i (wdata_i[KEY_W-1:0]),
    .key_o   (key_q)
  );

  ckb_mode_reg #(.DATA_W(DATA_W)) u_mode (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_psel_i (wr_i && addr_i == ADDR_W'(A_PSEL)),
    .wr_mode_i (wr_i && addr_i == ADDR_W'(A_MODE)),
    .wdata_i   (wdata_i),
    .key_i     (key_q),
    .pll_en_i  (pll_en_i),
    .psel_o    (psel_q),
    .mode_o    (mode_q)
  );

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_hit
    assign field_hit[f] = wr_i && addr_i == ADDR_W'(FIELD_BASE + f);
  end

  ckb_field_gate #(.NF(NUM_FIELDS)) u_gate (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .hit_i      (field_hit),
    .key0_i     (key_q[0]),
    .clk_lock_i (mode_q.clk_lock),
    .wdt_lock_i (mode_q.wdt_lock),
    .gate_o     (field_gate_o)
  );

  always_comb begin
    rd_next = '0;
    if (addr_i == ADDR_W'(A_KEY)) begin
      rd_next[KEY_W-1:0] = key_q;
    end else if (addr_i == ADDR_W'(A_PSEL)) begin
      rd_next[1:0] = psel_q;
    end else if (addr_i == ADDR_W'(A_MODE)) begin
      rd_next[0] = mode_q.one_wait;
      rd_next[1] = mode_q.clk_lock;
      rd_next[2] = mode_q.wdt_lock;
      rd_next[4] = mode_q.nmi;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rd_data_o <= '0;
    else       rd_data_o <= rd_next;
  end

  assign tmr_clk_full_o = psel_q[0];
  assign sio_clk_full_o = psel_q[1];
  assign sfr_one_wait_o = mode_q.one_wait;
  assign bclk_keep_o    = mode_q.clk_lock;
  assign wdt_ring_src_o = mode_q.wdt_lock;
  assign nmi_mode_o     = mode_q.nmi;

  p_mode_rsvd_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(addr_i) == ADDR_W'(A_MODE) |-> rd_data_o[3] == 1'b0 && rd_data_o[DATA_W-1:5] == '0);
endmodule

// File: tb/sim_clkctl_guard_bank.sv
module sim_clkctl_guard_bank;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic       wr;
  logic       pll;
  logic [7:0] rd;
  logic       tmr, sio, onew, bkeep, wring, nmi;
  logic [4:0] gate;

  int checks = 0;
  int fails  = 0;

  logic [1:0] m_key, m_psel;
  logic       m_wait, m_clk, m_wdt, m_nmi;

  always #4 clk = ~clk;

  clkctl_guard_bank u0 (
    .clk_i(clk), .rst_i(rst), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .pll_en_i(pll), .rd_data_o(rd), .tmr_clk_full_o(tmr), .sio_clk_full_o(sio),
    .sfr_one_wait_o(onew), .bclk_keep_o(bkeep), .wdt_ring_src_o(wring),
    .nmi_mode_o(nmi), .field_gate_o(gate)
  );

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0:    return {6'd0, m_key};
      4'd1:    return {6'd0, m_psel};
      4'd2:    return {3'd0, m_nmi, 1'b0, m_wdt, m_clk, m_wait};
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [4:0] exp_gate(input logic w, input logic [3:0] a);
    logic [4:0] g = '0;
    if (w && m_key[0] && a >= 4'd8 && a <= 4'd12 && !m_clk)
      if (!(a == 4'd10 && m_wdt)) g[a-4'd8] = 1'b1;
    return g;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_key = 2'b00; m_psel = 2'b11;
    m_wait = 0; m_clk = 0; m_wdt = 0; m_nmi = 0;
  endtask

  task automatic do_reset();
    rst = 1; wr = 0; addr = 0; wdata = 0; pll = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  task automatic step(input logic w, input logic [3:0] a, input logic [7:0] d, input logic p);
    logic [7:0] er;
    logic [4:0] eg;
    string      rtag;
    wr = w; addr = a; wdata = d; pll = p;
    er = exp_read(a);
    eg = exp_gate(w, a);
    if (w && a == 4'd0) m_key = d[1:0];
    if (w && a == 4'd1 && m_key[0]) m_psel = d[1:0];
    if (w && a == 4'd2 && m_key[1] && !(p && d[0] != m_wait)) begin
      m_wait = d[0]; m_clk |= d[1]; m_wdt |= d[2]; m_nmi |= d[4];
    end
    @(negedge clk);
    wr = 0;
    rtag = (a == 4'd1) ? "R2" : (a == 4'd2) ? "R8" : "R10";
    check(rtag, rd, er);
    check(m_clk ? "R5" : "R9", {3'd0, gate}, {3'd0, eg});
    check("R2", {6'd0, sio, tmr}, {6'd0, m_psel});
    check("R4", {7'd0, onew}, {7'd0, m_wait});
    check("R5", {7'd0, bkeep}, {7'd0, m_clk});
    check("R6", {7'd0, wring}, {7'd0, m_wdt});
    check("R7", {7'd0, nmi}, {7'd0, m_nmi});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1: reset contents
    step(0, 4'd1, 0, 0); check("R1", rd, 8'h03);
    step(0, 4'd2, 0, 0); check("R1", rd, 8'h00);
    step(0, 4'd0, 0, 0); check("R1", {3'd0, gate}, 8'h00);
    // R2: key closed -> no effect, then open
    step(1, 4'd1, 8'hFC, 0); step(0, 4'd1, 0, 0); check("R2", rd, 8'h03);
    step(1, 4'd0, 8'h01, 0); step(1, 4'd1, 8'hFE, 0); step(0, 4'd1, 0, 0); check("R2", rd, 8'h02);
    // R3: mode needs key bit 1
    step(1, 4'd2, 8'h01, 0); step(0, 4'd2, 0, 0); check("R3", rd, 8'h00);
    step(1, 4'd0, 8'h03, 0); step(0, 4'd0, 0, 0); check("R3", rd, 8'h03);
    // R4: PLL on, wait change drops whole write including lock bits
    step(1, 4'd2, 8'h17, 1); step(0, 4'd2, 0, 0); check("R4", rd, 8'h00);
    // PLL on, wait unchanged: nmi accepted (R7), reserved bits cleared (R8)
    step(1, 4'd2, 8'hF8, 1); step(0, 4'd2, 0, 0); check("R7", rd, 8'h10);
    step(1, 4'd2, 8'h01, 0); step(1, 4'd2, 8'h00, 0); step(0, 4'd2, 0, 0); check("R7", rd, 8'h10);
    // R9: each field gate
    for (int f = 0; f < 5; f++) begin
      step(1, 4'(8 + f), 8'h00, 0); check("R9", {3'd0, gate}, 8'(1 << f));
      step(0, 4'(8 + f), 8'h00, 0); check("R9", {3'd0, gate}, 8'h00);
    end
    // R6: watchdog lock blocks stop gate only
    step(1, 4'd2, 8'h04, 0);
    step(1, 4'd10, 0, 0); check("R6", {3'd0, gate}, 8'h00);
    step(1, 4'd9, 0, 0);  check("R6", {3'd0, gate}, 8'h02);
    // R5: clock lock blocks all, sticky
    step(1, 4'd2, 8'h02, 0); step(1, 4'd2, 8'h00, 0);
    step(1, 4'd8, 0, 0); check("R5", {3'd0, gate}, 8'h00);
    step(0, 4'd2, 0, 0); check("R5", rd, 8'h16);
    // R10: unmapped address reads 0
    step(0, 4'd15, 0, 0); check("R10", rd, 8'h00);
    // random epochs
    for (int e = 0; e < 40; e++) begin
      do_reset();
      for (int i = 0; i < 60; i++) begin
        logic [3:0] a;
        logic [7:0] d;
        int sel = $urandom % 9;
        a = (sel < 3) ? 4'(sel) : (sel < 8) ? 4'(5 + sel) : 4'(($urandom % 2) ? 3 : 15);
        d = 8'($urandom) & 8'hE9;
        if ($urandom % 10 == 0) d[1] = 1'b1;
        if ($urandom % 8 == 0)  d[2] = 1'b1;
        if ($urandom % 8 == 0)  d[4] = 1'b1;
        step(($urandom % 10) < 7, a, d, ($urandom % 10) < 3);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule